// File: doc/BRIEF.md
# Standby Power-Down Sequencer

This block takes a processor-style chip into a deep low-power standby state and brings it back out. Standby needs two things from software. It must first arm an enable bit in the control register. It must then issue a sleep strobe. When both are present, the sequencer drops the CPU clock enable, the peripheral clock enable and the external clock output enable together. It also clears the timer start register and the converter control register, and it moves a two-bit status output to the standby code. All other configuration is kept.

A non-maskable interrupt, any external interrupt line, a non-zero level-encoded interrupt, or a peripheral interrupt ends standby. None of these restarts the clocks at once. Each one starts a settling interval instead, in which a counter climbs from a programmed preload to overflow. The counter advances at a prescaled rate picked by a 3-bit field. The clocks come back on the overflow, and a one-cycle acknowledge tells the CPU it may resume. A synchronous reset leaves either low-power state in the next cycle, with no settling, and clears every control bit.

Register map on the write port (2-bit address):

- Address 0 (control):
  - bit 0 arms standby.
  - bit 1 is the watchdog run bit.
  - bits 4:2 select the prescale.
- Address 1: settling preload.
- Address 2: timer start bits.
- Address 3: converter control.

Top module: `pds_standby_ctrl`

## Requirements
- R1: After reset the three clock enables are 1. The status output is 2'b00, the acknowledge is 0, and the timer start and converter control outputs are 0.
- R2: A sleep strobe while the arm bit (address 0, bit 0) is 0 has no effect. The clocks stay on and the registers keep their values.
- R3: A sleep strobe sampled while the arm bit is 1 and the watchdog run bit (address 0, bit 1) is 0 enters standby. From the next cycle all three clock enables are 0 and the status output is 2'b01 (bit 1 low, bit 0 high).
- R4: A sleep strobe while the watchdog run bit is 1 is refused, and the chip keeps running.
- R5: On entry the timer start register (address 2) and the converter control register (address 3) read 0. The arm bit, the prescale select and the preload keep their values across standby.
- R6: In standby, each of these starts the settling interval:
  - the non-maskable input,
  - any bit of the external interrupt vector,
  - a non-zero level-encoded interrupt code,
  - the peripheral interrupt.
  A level code of 0 with the other sources low keeps the block in standby.
- R7: The clocks come back exactly (2^CNT_W − preload) × D clock edges after the edge that samples the wake. D is 1, 4, 16, 32, 64, 256, 1024 or 4096 for select codes 0 to 7.
- R8: While settling, the status stays 2'b01 and the clocks stay off. Once running, the status is 2'b00.
- R9: The acknowledge is high for exactly one cycle, in the first cycle in which the clocks are back on.
- R10: A reset during standby or settling restores the running outputs in the next cycle with no settling, and clears the arm bit.
- R11: Wake inputs while running have no effect. A wake or sleep strobe during settling does not restart or lengthen the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DW | Register write data |
| sleep_req | input | 1 | Sleep strobe from the CPU |
| wake_nmi | input | 1 | Non-maskable interrupt |
| wake_irq | input | IRQ_N | External interrupt lines |
| wake_irl | input | 4 | Level-encoded interrupt code, 0 means none |
| wake_periph | input | 1 | On-chip peripheral interrupt |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| clk_out_en | output | 1 | External clock output enable |
| stat_o | output | 2 | Power status, 00 running, 01 standby or settling |
| wake_ack | output | 1 | One-cycle resume pulse |
| tmr_start_o | output | TMR_W | Timer start register |
| conv_ctrl_o | output | DW | Converter control register |

## Verification
The assertions assume three things about the inputs. Reset is held for at least one cycle before any property is checked. The sleep strobe and the wake inputs are plain synchronous levels. Software follows the entry procedure, so the watchdog run bit is cleared before a sleep that is meant to enter standby. The stimulus drives every input on the falling edge, leaves inputs stable for a whole cycle, and only writes registers while the chip is running. Separate cases drive an armed watchdog and wake pulses in forbidden states on purpose, to show that they are refused or ignored.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [1:0] {
    PD_RUN    = 2'd0,
    PD_STBY   = 2'd1,
    PD_SETTLE = 2'd2
  } pd_state_t;

  localparam int ADDR_W   = 2;
  localparam int PRE_W    = 12;
  localparam int SEL_W    = 3;

  localparam logic [ADDR_W-1:0] A_CTRL    = 2'd0;
  localparam logic [ADDR_W-1:0] A_PRELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_TMR     = 2'd2;
  localparam logic [ADDR_W-1:0] A_CONV    = 2'd3;

  localparam logic [1:0] ST_RUNNING = 2'b00;
  localparam logic [1:0] ST_LOWPWR  = 2'b01;

  // Prescale log2 per select code: 0,2,4,5,6,8,10,12
  function automatic int pre_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 8;
      3'd6:    return 10;
      default: return 12;
    endcase
  endfunction

  function automatic logic [PRE_W-1:0] pre_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << pre_shift(sel);
    return PRE_W'(one_hot - 1'b1);
  endfunction

endpackage

// File: rtl/pds_regs.sv
module pds_regs
  import pds_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 8,
  parameter int TMR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              clr_entry,
  output logic              stby_en,
  output logic              wdt_en,
  output logic [SEL_W-1:0]  csel,
  output logic [CNT_W-1:0]  preload,
  output logic [TMR_W-1:0]  tmr_start,
  output logic [DW-1:0]     conv_ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stby_en   <= 1'b0;
      wdt_en    <= 1'b0;
      csel      <= '0;
      preload   <= '0;
      tmr_start <= '0;
      conv_ctrl <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            stby_en <= wr_data[0];
            wdt_en  <= wr_data[1];
            csel    <= wr_data[2 +: SEL_W];
          end
          A_PRELOAD: preload   <= wr_data[CNT_W-1:0];
          A_TMR:     tmr_start <= wr_data[TMR_W-1:0];
          default:   conv_ctrl <= wr_data;
        endcase
      end
      if (clr_entry) begin
        tmr_start <= '0;
        conv_ctrl <= '0;
      end
    end
  end

endmodule

// File: rtl/pds_prescale.sv
module pds_prescale
  import pds_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] mask;

  assign mask = pre_mask(sel);
  assign tick = run && ((pcnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + 1'b1;
  end

endmodule

// File: rtl/pds_settle.sv
module pds_settle #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] preload,
  input  logic             tick,
  output logic             ovf
);

  logic [CNT_W-1:0] cnt_q;

  assign ovf = tick && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= preload;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pds_standby_ctrl.sv
module pds_standby_ctrl
  import pds_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 8,
  parameter int TMR_W = 4,
  parameter int IRQ_N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              sleep_req,
  input  logic              wake_nmi,
  input  logic [IRQ_N-1:0]  wake_irq,
  input  logic [3:0]        wake_irl,
  input  logic              wake_periph,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic              clk_out_en,
  output logic [1:0]        stat_o,
  output logic              wake_ack,
  output logic [TMR_W-1:0]  tmr_start_o,
  output logic [DW-1:0]     conv_ctrl_o
);

  pd_state_t        state_q, state_d;
  logic             stby_en_q, wdt_en_q;
  logic [SEL_W-1:0] csel_q;
  logic [CNT_W-1:0] preload_q;
  logic             enter, load, done, tick, ovf, any_wake;

  pds_regs #(.DW(DW), .CNT_W(CNT_W), .TMR_W(TMR_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .clr_entry (enter),
    .stby_en   (stby_en_q),
    .wdt_en    (wdt_en_q),
    .csel      (csel_q),
    .preload   (preload_q),
    .tmr_start (tmr_start_o),
    .conv_ctrl (conv_ctrl_o)
  );

  pds_prescale i_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == PD_SETTLE),
    .sel  (csel_q),
    .tick (tick)
  );

  pds_settle #(.CNT_W(CNT_W)) i_settle (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .preload (preload_q),
    .tick    (tick),
    .ovf     (ovf)
  );

  assign any_wake = wake_nmi || (|wake_irq) || (wake_irl != 4'd0) || wake_periph;

  always_comb begin
    state_d = state_q;
    enter   = 1'b0;
    load    = 1'b0;
    done    = 1'b0;
    case (state_q)
      PD_RUN: begin
        if (sleep_req && stby_en_q && !wdt_en_q) begin
          state_d = PD_STBY;
          enter   = 1'b1;
        end
      end
      PD_STBY: begin
        if (any_wake) begin
          state_d = PD_SETTLE;
          load    = 1'b1;
        end
      end
      PD_SETTLE: begin
        if (ovf) begin
          state_d = PD_RUN;
          done    = 1'b1;
        end
      end
      default: state_d = PD_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= PD_RUN;
      cpu_clk_en    <= 1'b1;
      periph_clk_en <= 1'b1;
      clk_out_en    <= 1'b1;
      stat_o        <= ST_RUNNING;
      wake_ack      <= 1'b0;
    end else begin
      state_q       <= state_d;
      cpu_clk_en    <= (state_d == PD_RUN);
      periph_clk_en <= (state_d == PD_RUN);
      clk_out_en    <= (state_d == PD_RUN);
      stat_o        <= (state_d == PD_RUN) ? ST_RUNNING : ST_LOWPWR;
      wake_ack      <= done;
    end
  end

endmodule

// File: rtl/pds_standby_chk.sv
module pds_standby_chk #(
  parameter int DW    = 8,
  parameter int TMR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_req,
  input logic             stby_en,
  input logic             cpu_clk_en,
  input logic             periph_clk_en,
  input logic             clk_out_en,
  input logic [1:0]       stat_o,
  input logic             wake_ack,
  input logic [TMR_W-1:0] tmr_start_o,
  input logic [DW-1:0]    conv_ctrl_o
);

  AST_GATES_MATCH: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en == periph_clk_en) && (cpu_clk_en == clk_out_en)); // R3

  AST_LOWPWR_CODE: assert property (@(posedge clk) disable iff (rst)
    !cpu_clk_en |-> stat_o == 2'b01); // R8

  AST_RUN_CODE: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> stat_o == 2'b00); // R8

  AST_UNARMED_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_req && !stby_en) |=> cpu_clk_en); // R2

  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_clk_en) |-> (tmr_start_o == '0) && (conv_ctrl_o == '0)); // R5

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wake_ack |=> !wake_ack); // R9

  AST_ACK_AT_RESUME: assert property (@(posedge clk) disable iff (rst)
    wake_ack |-> cpu_clk_en && $past(!cpu_clk_en)); // R9

  AST_RESUME_ACKED: assert property (@(posedge clk) disable iff (rst)
    ($rose(cpu_clk_en) && !$past(rst)) |-> wake_ack); // R9

endmodule

bind pds_standby_ctrl pds_standby_chk #(.DW(DW), .TMR_W(TMR_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .sleep_req     (sleep_req),
  .stby_en       (stby_en_q),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .clk_out_en    (clk_out_en),
  .stat_o        (stat_o),
  .wake_ack      (wake_ack),
  .tmr_start_o   (tmr_start_o),
  .conv_ctrl_o   (conv_ctrl_o)
);

// File: tb/test_pds_standby_ctrl.sv
module test_pds_standby_ctrl;

  localparam int DW = 8, CNT_W = 8, TMR_W = 4, IRQ_N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic sleep_req = 1'b0, wake_nmi = 1'b0, wake_periph = 1'b0;
  logic [IRQ_N-1:0] wake_irq = '0;
  logic [3:0] wake_irl = '0;
  logic cpu_clk_en, periph_clk_en, clk_out_en, wake_ack;
  logic [1:0] stat_o;
  logic [TMR_W-1:0] tmr_start_o;
  logic [DW-1:0] conv_ctrl_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pds_standby_ctrl #(.DW(DW), .CNT_W(CNT_W), .TMR_W(TMR_W), .IRQ_N(IRQ_N)) i_pds_standby_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sleep_req(sleep_req), .wake_nmi(wake_nmi), .wake_irq(wake_irq),
    .wake_irl(wake_irl), .wake_periph(wake_periph), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .clk_out_en(clk_out_en), .stat_o(stat_o),
    .wake_ack(wake_ack), .tmr_start_o(tmr_start_o), .conv_ctrl_o(conv_ctrl_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sleep_pulse();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic wake_pulse(input int src);
    case (src % 4)
      0: wake_nmi = 1'b1;
      1: wake_irq[src % IRQ_N] = 1'b1;
      2: wake_irl = 4'(1 + src % 15);
      default: wake_periph = 1'b1;
    endcase
    @(negedge clk);
    wake_nmi = 1'b0; wake_irq = '0; wake_irl = '0; wake_periph = 1'b0;
  endtask

  function automatic int div_of(input int sel);
    case (sel)
      0: return 1;    1: return 4;    2: return 16;   3: return 32;
      4: return 64;   5: return 256;  6: return 1024; default: return 4096;
    endcase
  endfunction

  // Counts edges from the wake sample to clock re-enable
  task automatic settle_measure(input int exp_cyc, input string req, input int poke_at);
    int k;
    bit st_ok;
    k = 0; st_ok = 1'b1;
    while (cpu_clk_en == 1'b0 && k < exp_cyc + 8) begin
      if (k == poke_at) begin wake_nmi = 1'b1; sleep_req = 1'b1; end
      @(negedge clk);
      wake_nmi = 1'b0; sleep_req = 1'b0;
      k++;
      if (cpu_clk_en == 1'b0 && stat_o != 2'b01) st_ok = 1'b0;
    end
    chk(req, k, exp_cyc);
    chk("R8 status held during settling", int'(st_ok), 1);
    chk("R8 status running after resume", int'(stat_o), 0);
    chk("R9 ack at resume", int'(wake_ack), 1);
    @(negedge clk);
    chk("R9 ack lasts one cycle", int'(wake_ack), 0);
  endtask

  task automatic enter_ok(input string req);
    sleep_pulse();
    chk({req, " cpu clock off"}, int'(cpu_clk_en), 0);
    chk({req, " periph clock off"}, int'(periph_clk_en), 0);
    chk({req, " clock out off"}, int'(clk_out_en), 0);
    chk({req, " status 01"}, int'(stat_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cpu clk", int'(cpu_clk_en), 1);
    chk("R1 periph clk", int'(periph_clk_en), 1);
    chk("R1 clk out", int'(clk_out_en), 1);
    chk("R1 status", int'(stat_o), 0);
    chk("R1 ack", int'(wake_ack), 0);
    chk("R1 timer", int'(tmr_start_o), 0);
    chk("R1 conv", int'(conv_ctrl_o), 0);

    // R2 unarmed sleep
    wr(2'd2, 8'h0F); wr(2'd3, 8'hA5); wr(2'd0, 8'h00);
    sleep_pulse(); @(negedge clk);
    chk("R2 unarmed sleep clocks", int'(cpu_clk_en), 1);
    chk("R2 unarmed sleep timer kept", int'(tmr_start_o), 15);
    chk("R2 unarmed sleep conv kept", int'(conv_ctrl_o), 165);

    // R4 watchdog running refuses entry
    wr(2'd0, 8'h03);
    sleep_pulse(); @(negedge clk);
    chk("R4 watchdog armed refused", int'(cpu_clk_en), 1);
    chk("R4 status", int'(stat_o), 0);

    // R11 wake while running
    wake_pulse(0); wake_pulse(3);
    chk("R11 wake while running clocks", int'(cpu_clk_en), 1);
    chk("R11 wake while running ack", int'(wake_ack), 0);

    // R3 / R5 entry
    wr(2'd0, 8'h01); wr(2'd1, 8'd250);
    enter_ok("R3");
    chk("R5 timer cleared", int'(tmr_start_o), 0);
    chk("R5 conv cleared", int'(conv_ctrl_o), 0);

    // R6 idle standby, irl 0 is no wake
    wake_irl = 4'd0;
    repeat (20) @(negedge clk);
    chk("R6 no wake stays in standby", int'(cpu_clk_en), 0);
    sleep_pulse();
    chk("R6 sleep in standby stays", int'(cpu_clk_en), 0);
    wake_pulse(0);
    settle_measure(6, "R7 preload 250 div 1", -1);

    // R11 poke during settle does not restart
    wr(2'd1, 8'd200);
    enter_ok("R3 re-entry");
    wake_pulse(1);
    settle_measure(56, "R11 poke during settling", 10);

    // R7 / R6 sweep of every prescale with each wake source; R5 retention
    wr(2'd1, 8'd254);
    for (int s = 0; s < 8; s++) begin
      wr(2'd0, 8'(1 + (s << 2)));
      enter_ok("R3 sweep");
      wake_pulse(s);
      settle_measure(2 * div_of(s), $sformatf("R7 select %0d", s), -1);
    end

    // R7 exhaustive preload at select 0, arm bit retained (R5)
    wr(2'd0, 8'h01);
    for (int p = 0; p < 256; p++) begin
      wr(2'd1, 8'(p));
      enter_ok("R5 arm retained");
      wake_pulse(p);
      settle_measure(256 - p, $sformatf("R7 preload %0d", p), -1);
    end

    // R10 reset during settling
    wr(2'd1, 8'd0); wr(2'd2, 8'h05);
    enter_ok("R3");
    wake_pulse(2);
    repeat (3) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R10 reset in settling clocks", int'(cpu_clk_en), 1);
    chk("R10 reset in settling status", int'(stat_o), 0);
    chk("R10 reset no ack", int'(wake_ack), 0);
    sleep_pulse(); @(negedge clk);
    chk("R10 arm bit cleared", int'(cpu_clk_en), 1);

    // R10 reset in standby
    wr(2'd0, 8'h01); wr(2'd3, 8'h33);
    enter_ok("R3");
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R10 reset in standby clocks", int'(clk_out_en), 1);
    chk("R10 reset in standby conv", int'(conv_ctrl_o), 0);

    summary();
  end

endmodule